// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves bytes between a simple memory port and a single peripheral stream port. Software loads transfer descriptors into two alternating slots. Each slot holds a byte count and a start address. While the channel works through one slot, software can refill the other, so the byte stream continues without a gap between buffers.

A four-state sequencer tracks how many buffers the channel holds: idle, stall (enabled, no buffer), on (one buffer) and next (one buffer active, one waiting). Software reads this state from the status register. The channel raises a stall interrupt when it runs dry and a next-buffer interrupt when it moves from one slot to the other, which frees a slot for refilling. A peripheral error input latches an error flag.

Disabling the channel is graceful. Buffers already accepted are drained to the end, and only then does the channel fall back to idle. A direction bit selects the transfer direction: memory-to-peripheral, or peripheral-to-memory.

Top module: `dbd_dma_channel`

## Requirements
- R1: After reset, the control, interrupt, status and remaining-count registers all read 0. `irq`, `mem_req` and `pout_valid` are low.
- R2: Status bits [5:4] hold the channel state (0 idle, 1 stall, 2 on, 3 next). Writing 1 to control bit 4 (enable) moves the channel from idle to stall. Idle never leads directly to on or next.
- R3: Every time the channel leaves idle, the first descriptor must go into slot 0 (count at 0x20, address at 0x24). After that, slots alternate. A write to the address register of the slot not expected next is ignored, and the state stays the same.
- R4: Writing the expected slot's address register (0x24 or 0x34) moves the state from stall to on, or from on to next. The same write is ignored in next, in idle, and while enable is 0.
- R5: With control bit 5 = 0, the channel reads bytes from consecutive memory addresses, starting at the slot address. It delivers them in order on `pout_data`, holding `pout_valid` and the data until `pout_ready`. Register 0x14 reads the bytes left in the active buffer and falls by one per byte.
- R6: With control bit 5 = 1, the channel accepts bytes from `pin_data` and writes them to consecutive memory addresses, starting at the slot address.
- R7: When the active buffer ends in next, the channel switches to the other slot, the state becomes on, and interrupt bit 1 (next-buffer) is set.
- R8: When the active buffer ends in on, the state becomes stall and interrupt bit 0 (stall) is set.
- R9: Every accepted descriptor clears interrupt bits 0 and 1.
- R10: A pulse on `err_in` sets interrupt bit 3 and leaves the state unchanged. Writing 1 to bit 3 of 0x04 clears it. Writing 0 there leaves it set.
- R11: `irq` is high exactly when one of these holds: interrupt bit 0 and control bit 0 are both set; interrupt bit 1 and control bit 1 are both set; interrupt bit 3 and control bit 3 are both set.
- R12: Clearing enable in on or next does not stop the channel: it finishes its buffers, reaches stall, then goes idle. Clearing enable in stall gives idle on the next cycle.
- R13: A descriptor with a count of 0 completes without moving any byte.
- R14: Register 0x08 holds the peripheral select value, drives `port_sel` and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access completes this cycle |
| pout_valid | output | 1 | Byte to peripheral is valid |
| pout_data | output | DATA_W | Byte to peripheral |
| pout_ready | input | 1 | Peripheral takes the byte |
| pin_valid | input | 1 | Byte from peripheral is valid |
| pin_data | input | DATA_W | Byte from peripheral |
| pin_ready | output | 1 | Channel takes the byte |
| err_in | input | 1 | Peripheral error pulse |
| port_sel | output | PORT_W | Selected peripheral port |
| irq | output | 1 | Level interrupt |

## Verification
Two buffer transitions are hard to reach from the ports. One is the next-to-on switch, which needs a second descriptor accepted while the first is still running. The other is the drain after enable is cleared while a buffer is unfinished. The bench reaches both by holding `pout_ready` low: the channel stalls on its first fetched byte while descriptors and control writes are applied. The bench then releases `pout_ready` and checks the byte sequence, the state and the interrupt bits once the channel settles.

// File: rtl/dbd_pkg.sv
// Package dbd_pkg: shared types and register layout for the double-buffered
// DMA channel. Assumes byte offsets on an 8-bit register address.
package dbd_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_STALL = 2'd1,
        CH_ON    = 2'd2,
        CH_NEXT  = 2'd3
    } chan_st_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_INT    = 8'h04;
    localparam logic [7:0] OFS_PORT   = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h0C;
    localparam logic [7:0] OFS_REMAIN = 8'h14;
    localparam logic [7:0] OFS_CNT0   = 8'h20;
    localparam logic [7:0] OFS_BASE0  = 8'h24;
    localparam logic [7:0] OFS_CNT1   = 8'h30;
    localparam logic [7:0] OFS_BASE1  = 8'h34;

    localparam int CB_IE_STALL = 0;
    localparam int CB_IE_NFB   = 1;
    localparam int CB_IE_ERR   = 3;
    localparam int CB_EN       = 4;
    localparam int CB_DIR      = 5;

    localparam int IB_STALL = 0;
    localparam int IB_NFB   = 1;
    localparam int IB_ERR   = 3;

endpackage

// File: rtl/dbd_regs.sv
// Module dbd_regs: register file of the channel. Holds control, port select,
// both descriptor slots and the error flag. Decodes address writes into
// descriptor hand-over pulses and builds the interrupt line.
// Assumes single-cycle writes and a combinational read path.
module dbd_regs
    import dbd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int PORT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wen,
    input  logic [7:0]             addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic                   err_in,
    input  logic                   stall_flag,
    input  logic                   nfb_flag,
    input  chan_st_e               st,
    input  logic [CNT_W-1:0]       remain,
    output logic                   ctl_en,
    output logic                   ctl_dir,
    output logic [PORT_W-1:0]      port_sel,
    output logic [1:0][CNT_W-1:0]  slot_cnt,
    output logic [1:0][ADDR_W-1:0] slot_base,
    output logic                   base_wr,
    output logic                   base_slot,
    output logic                   irq
);

    logic ie_stall, ie_nfb, ie_err;
    logic err_q;
    logic err_clr;

    assign err_clr = wen && (addr == OFS_INT) && wdata[IB_ERR];

    // Control and port select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_stall <= 1'b0;
            ie_nfb   <= 1'b0;
            ie_err   <= 1'b0;
            ctl_en   <= 1'b0;
            ctl_dir  <= 1'b0;
            port_sel <= '0;
        end else if (wen) begin
            if (addr == OFS_CTRL) begin
                ie_stall <= wdata[CB_IE_STALL];
                ie_nfb   <= wdata[CB_IE_NFB];
                ie_err   <= wdata[CB_IE_ERR];
                ctl_en   <= wdata[CB_EN];
                ctl_dir  <= wdata[CB_DIR];
            end
            if (addr == OFS_PORT) port_sel <= wdata[PORT_W-1:0];
        end
    end

    // Sticky error flag; a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_in)  err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // One count/address register pair per descriptor slot.
    for (genvar g = 0; g < 2; g++) begin : g_slot
        localparam logic [7:0] CNT_OFS  = (g == 0) ? OFS_CNT0  : OFS_CNT1;
        localparam logic [7:0] BASE_OFS = (g == 0) ? OFS_BASE0 : OFS_BASE1;
        logic [CNT_W-1:0]  cnt_q;
        logic [ADDR_W-1:0] base_q;

        // Capture slot fields on their register writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                base_q <= '0;
            end else if (wen) begin
                if (addr == CNT_OFS)  cnt_q  <= wdata[CNT_W-1:0];
                if (addr == BASE_OFS) base_q <= wdata[ADDR_W-1:0];
            end
        end

        assign slot_cnt[g]  = cnt_q;
        assign slot_base[g] = base_q;
    end

    assign base_wr   = wen && ((addr == OFS_BASE0) || (addr == OFS_BASE1));
    assign base_slot = (addr == OFS_BASE1);

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL:   rdata = 32'({ctl_dir, ctl_en, ie_err, 1'b0, ie_nfb, ie_stall});
            OFS_INT:    rdata = 32'({err_q, 1'b0, nfb_flag, stall_flag});
            OFS_PORT:   rdata = 32'(port_sel);
            OFS_STAT:   rdata = 32'({st, 4'b0000});
            OFS_REMAIN: rdata = 32'(remain);
            OFS_CNT0:   rdata = 32'(slot_cnt[0]);
            OFS_BASE0:  rdata = 32'(slot_base[0]);
            OFS_CNT1:   rdata = 32'(slot_cnt[1]);
            OFS_BASE1:  rdata = 32'(slot_base[1]);
            default:    rdata = '0;
        endcase
    end

    // Level interrupt from enabled sources.
    assign irq = (stall_flag & ie_stall) | (nfb_flag & ie_nfb) | (err_q & ie_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);

endmodule

// File: rtl/dbd_seq.sv
// Module dbd_seq: four-state slot sequencer. Accepts descriptors in strict
// slot alternation, keeps the active byte count and address, switches slots
// when a buffer ends and raises the stall / next-buffer flags.
// Assumes byte_done only arrives while the active count is non-zero.
module dbd_seq
    import dbd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   base_wr,
    input  logic                   base_slot,
    input  logic [ADDR_W-1:0]      base_wdata,
    input  logic [1:0][CNT_W-1:0]  slot_cnt,
    input  logic [1:0][ADDR_W-1:0] slot_base,
    input  logic                   byte_done,
    output chan_st_e               st,
    output logic [CNT_W-1:0]       cnt,
    output logic [ADDR_W-1:0]      addr,
    output logic                   active,
    output logic                   stall_flag,
    output logic                   nfb_flag
);

    logic nxt_slot;
    logic cur_slot;
    logic acc;
    logic complete;

    assign acc      = base_wr && (base_slot == nxt_slot) && en &&
                      ((st == CH_STALL) || (st == CH_ON));
    assign active   = (st == CH_ON) || (st == CH_NEXT);
    assign complete = active && (cnt == '0);

    // State, slot pointers, active count/address and event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= CH_IDLE;
            nxt_slot   <= 1'b0;
            cur_slot   <= 1'b0;
            cnt        <= '0;
            addr       <= '0;
            stall_flag <= 1'b0;
            nfb_flag   <= 1'b0;
        end else begin
            if (byte_done) begin
                cnt  <= cnt - 1'b1;
                addr <= addr + 1'b1;
            end
            if (acc) begin
                nxt_slot   <= ~nxt_slot;
                stall_flag <= 1'b0;
                nfb_flag   <= 1'b0;
            end
            case (st)
                CH_IDLE: if (en) begin
                    st         <= CH_STALL;
                    nxt_slot   <= 1'b0;
                    cur_slot   <= 1'b0;
                    stall_flag <= 1'b0;
                    nfb_flag   <= 1'b0;
                end
                CH_STALL: if (!en) begin
                    st <= CH_IDLE;
                end else if (acc) begin
                    st       <= CH_ON;
                    cur_slot <= base_slot;
                    cnt      <= slot_cnt[base_slot];
                    addr     <= base_wdata;
                end
                CH_ON: if (complete) begin
                    if (acc) begin
                        cur_slot <= base_slot;
                        cnt      <= slot_cnt[base_slot];
                        addr     <= base_wdata;
                    end else begin
                        st         <= CH_STALL;
                        stall_flag <= 1'b1;
                    end
                end else if (acc) begin
                    st <= CH_NEXT;
                end
                CH_NEXT: if (complete) begin
                    st       <= CH_ON;
                    cur_slot <= ~cur_slot;
                    cnt      <= slot_cnt[~cur_slot];
                    addr     <= slot_base[~cur_slot];
                    nfb_flag <= 1'b1;
                end
                default: st <= CH_IDLE;
            endcase
        end
    end

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_IDLE) |=> (st == CH_IDLE) || (st == CH_STALL));

    assert_run_dry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == CH_ON && st == CH_STALL) |-> stall_flag);

    assert_slot_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == CH_NEXT && st == CH_ON) |-> nfb_flag);

endmodule

// File: rtl/dbd_mover.sv
// Module dbd_mover: one-byte-at-a-time data mover. A gather phase fetches a
// byte (memory read or peripheral input) and a deliver phase hands it on
// (peripheral output or memory write). Assumes a stable address while a
// byte is in flight.
module dbd_mover #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              dir,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              pout_valid,
    output logic [DATA_W-1:0] pout_data,
    input  logic              pout_ready,
    input  logic              pin_valid,
    input  logic [DATA_W-1:0] pin_data,
    output logic              pin_ready,
    output logic              byte_done
);

    logic              deliver;
    logic              xdir;
    logic [DATA_W-1:0] hold;
    logic              gather;
    logic              take;

    assign gather     = !deliver && go;
    assign mem_req    = (gather && !dir) || (deliver && xdir);
    assign mem_we     = deliver && xdir;
    assign mem_addr   = addr;
    assign mem_wdata  = hold;
    assign pout_valid = deliver && !xdir;
    assign pout_data  = hold;
    assign pin_ready  = gather && dir;
    assign take       = gather && (dir ? pin_valid : mem_ack);
    assign byte_done  = deliver && (xdir ? mem_ack : pout_ready);

    // Phase register and holding byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver <= 1'b0;
            xdir    <= 1'b0;
            hold    <= '0;
        end else if (take) begin
            deliver <= 1'b1;
            xdir    <= dir;
            hold    <= dir ? pin_data : mem_rdata;
        end else if (byte_done) begin
            deliver <= 1'b0;
        end
    end

    assert_out_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));

endmodule

// File: rtl/dbd_dma_channel.sv
// Module dbd_dma_channel: top of the double-buffered DMA channel. Connects
// the register file, the slot sequencer and the byte mover.
// Assumes one register access per cycle and a memory that acks each request.
module dbd_dma_channel
    import dbd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              pout_valid,
    output logic [DATA_W-1:0] pout_data,
    input  logic              pout_ready,
    input  logic              pin_valid,
    input  logic [DATA_W-1:0] pin_data,
    output logic              pin_ready,
    input  logic              err_in,
    output logic [PORT_W-1:0] port_sel,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_EMPTY = '0;

    chan_st_e               st;
    logic [CNT_W-1:0]       cnt;
    logic [ADDR_W-1:0]      cur_addr;
    logic                   active;
    logic                   stall_flag;
    logic                   nfb_flag;
    logic                   ctl_en;
    logic                   ctl_dir;
    logic [1:0][CNT_W-1:0]  slot_cnt;
    logic [1:0][ADDR_W-1:0] slot_base;
    logic                   base_wr;
    logic                   base_slot;
    logic                   byte_done;
    logic                   go;

    assign go = active && (cnt != CNT_EMPTY);

    dbd_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (reg_wen),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .err_in     (err_in),
        .stall_flag (stall_flag),
        .nfb_flag   (nfb_flag),
        .st         (st),
        .remain     (cnt),
        .ctl_en     (ctl_en),
        .ctl_dir    (ctl_dir),
        .port_sel   (port_sel),
        .slot_cnt   (slot_cnt),
        .slot_base  (slot_base),
        .base_wr    (base_wr),
        .base_slot  (base_slot),
        .irq        (irq)
    );

    dbd_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctl_en),
        .base_wr    (base_wr),
        .base_slot  (base_slot),
        .base_wdata (reg_wdata[ADDR_W-1:0]),
        .slot_cnt   (slot_cnt),
        .slot_base  (slot_base),
        .byte_done  (byte_done),
        .st         (st),
        .cnt        (cnt),
        .addr       (cur_addr),
        .active     (active),
        .stall_flag (stall_flag),
        .nfb_flag   (nfb_flag)
    );

    dbd_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .dir        (ctl_dir),
        .addr       (cur_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .pout_valid (pout_valid),
        .pout_data  (pout_data),
        .pout_ready (pout_ready),
        .pin_valid  (pin_valid),
        .pin_data   (pin_data),
        .pin_ready  (pin_ready),
        .byte_done  (byte_done)
    );

    assert_no_move_on_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (cnt != CNT_EMPTY));

endmodule

// File: tb/test_dbd_dma_channel.sv
// Directed bench for dbd_dma_channel: one task per scenario.
module test_dbd_dma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        pout_valid, pout_ready = 1'b0;
    logic [7:0]  pout_data;
    logic        pin_valid = 1'b0, pin_ready;
    logic [7:0]  pin_data = '0;
    logic        err_in = 1'b0;
    logic [3:0]  port_sel;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0]  tx_d [0:63];
    int tx_n = 0;
    logic [31:0] rx_a [0:63];
    logic [7:0]  rx_d [0:63];
    int rx_n = 0;

    always #10 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

    dbd_dma_channel i_dbd_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pout_valid(pout_valid),
        .pout_data(pout_data), .pout_ready(pout_ready), .pin_valid(pin_valid),
        .pin_data(pin_data), .pin_ready(pin_ready), .err_in(err_in),
        .port_sel(port_sel), .irq(irq)
    );

    // Record handshakes late in the cycle, before the next rising edge.
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (pout_valid && pout_ready && tx_n < 64) begin
                tx_d[tx_n] = pout_data;
                tx_n++;
            end
            if (mem_req && mem_we && rx_n < 64) begin
                rx_a[rx_n] = mem_addr;
                rx_d[rx_n] = mem_wdata;
                rx_n++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_state(input logic [1:0] s);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(8'h0C, v);
            if (v[5:4] == s) return;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h04, v); check("R1 int", v, 0);
        rd(8'h0C, v); check("R1 status", v, 0);
        rd(8'h14, v); check("R1 remain", v, 0);
        check("R1 outputs", {irq, mem_req, pout_valid}, 0);
    endtask

    task automatic t_enable_port;
        logic [31:0] v;
        wr(8'h00, 32'h10);
        rd(8'h0C, v); check("R2 idle to stall", v[5:4], 1);
        wr(8'h08, 32'h5);
        check("R14 port_sel", port_sel, 5);
        rd(8'h08, v); check("R14 readback", v, 5);
    endtask

    task automatic t_wrong_slot;
        logic [31:0] v;
        wr(8'h30, 32'd4);
        wr(8'h34, 32'h100);
        repeat (3) @(negedge clk);
        rd(8'h0C, v); check("R3 wrong slot ignored", v[5:4], 1);
        check("R3 no bytes", tx_n, 0);
    endtask

    task automatic t_tx_double;
        logic [31:0] v;
        logic [7:0] exp_b [5];
        exp_b = '{8'hE5, 8'hE4, 8'hE7, 8'h25, 8'h24};
        pout_ready = 1'b0;
        wr(8'h20, 32'd3); wr(8'h24, 32'h40);
        rd(8'h0C, v); check("R4 stall to on", v[5:4], 2);
        wr(8'h30, 32'd2); wr(8'h34, 32'h80);
        rd(8'h0C, v); check("R4 on to next", v[5:4], 3);
        wr(8'h24, 32'h50);
        rd(8'h0C, v); check("R4 ignored in next", v[5:4], 3);
        rd(8'h14, v); check("R5 remain before", v, 3);
        wr(8'h00, 32'h13);
        pout_ready = 1'b1;
        wait_state(2'd1);
        check("R5 R7 byte count", tx_n, 5);
        for (int i = 0; i < 5; i++) check("R5 R7 byte", tx_d[i], exp_b[i]);
        rd(8'h04, v); check("R7 R8 int bits", v, 3);
        rd(8'h14, v); check("R5 remain after", v, 0);
        check("R11 irq on", irq, 1);
        wr(8'h00, 32'h10);
        check("R11 irq masked", irq, 0);
    endtask

    task automatic t_flag_clear;
        logic [31:0] v;
        pout_ready = 1'b0;
        wr(8'h20, 32'd1); wr(8'h24, 32'h10);
        rd(8'h04, v); check("R9 flags cleared", v, 0);
        pout_ready = 1'b1;
        wait_state(2'd1);
        rd(8'h04, v); check("R8 stall only", v, 1);
        check("R5 single byte", tx_d[5], 8'hB5);
    endtask

    task automatic t_error;
        logic [31:0] v;
        pout_ready = 1'b0;
        wr(8'h30, 32'd2); wr(8'h34, 32'h20);
        @(negedge clk); err_in = 1'b1;
        @(negedge clk); err_in = 1'b0;
        rd(8'h04, v); check("R10 err set", v, 8);
        rd(8'h0C, v); check("R10 state kept", v[5:4], 2);
        wr(8'h04, 32'h0);
        rd(8'h04, v); check("R10 write 0 keeps", v, 8);
        wr(8'h00, 32'h18);
        check("R11 irq err", irq, 1);
        wr(8'h04, 32'h8);
        rd(8'h04, v); check("R10 cleared", v, 0);
        check("R11 irq clear", irq, 0);
        pout_ready = 1'b1;
        wait_state(2'd1);
        check("R10 bytes a", tx_d[6], 8'h85);
        check("R10 bytes b", tx_d[7], 8'h84);
        wr(8'h00, 32'h10);
    endtask

    task automatic t_drain;
        logic [31:0] v;
        int n0;
        pout_ready = 1'b0;
        wr(8'h20, 32'd2); wr(8'h24, 32'h60);
        wr(8'h00, 32'h00);
        rd(8'h0C, v); check("R12 still on", v[5:4], 2);
        pout_ready = 1'b1;
        wait_state(2'd0);
        rd(8'h0C, v); check("R12 idle", v[5:4], 0);
        check("R12 drained count", tx_n, 10);
        check("R12 drained a", tx_d[8], 8'hC5);
        check("R12 drained b", tx_d[9], 8'hC4);
        n0 = tx_n;
        wr(8'h20, 32'd1); wr(8'h24, 32'h70);
        repeat (4) @(negedge clk);
        rd(8'h0C, v); check("R4 ignored in idle", v[5:4], 0);
        check("R4 no move in idle", tx_n, n0);
        wr(8'h00, 32'h10);
        wr(8'h00, 32'h00);
        rd(8'h0C, v); check("R12 stall to idle", v[5:4], 0);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        int n0;
        wr(8'h00, 32'h10);
        n0 = tx_n;
        wr(8'h20, 32'd0); wr(8'h24, 32'h70);
        wait_state(2'd1);
        repeat (3) @(negedge clk);
        check("R13 no bytes", tx_n, n0);
        rd(8'h04, v); check("R13 stall flag", v, 1);
        rd(8'h0C, v); check("R13 back in stall", v[5:4], 1);
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        pin_valid = 1'b1; pin_data = d;
        #5;
        while (!pin_ready) begin
            @(negedge clk);
            #5;
        end
        @(negedge clk);
        pin_valid = 1'b0;
    endtask

    task automatic t_rx;
        int n0;
        n0 = tx_n;
        wr(8'h00, 32'h30);
        wr(8'h30, 32'd3); wr(8'h34, 32'h90);
        send_byte(8'h3A); send_byte(8'h3B); send_byte(8'h3C);
        wait_state(2'd1);
        check("R6 write count", rx_n, 3);
        for (int i = 0; i < 3; i++) begin
            check("R6 address", rx_a[i], 32'h90 + i);
            check("R6 data", rx_d[i], 8'h3A + i);
        end
        check("R6 no output bytes", tx_n, n0);
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_port();
        t_wrong_slot();
        t_tx_double();
        t_flag_clear();
        t_error();
        t_drain();
        t_zero();
        t_rx();
        finish_up();
    end

endmodule